// File: doc/BRIEF.md
# Serial Clock and Interval Timer Divider

This block holds one 16-bit reload counter that does two jobs for a serial peripheral interface controller. When the controller's 2-bit enable field is non-zero, the counter divides the system clock and sends a one-cycle strobe to the shifter each time the serial clock must toggle. The bit rate is therefore the system clock divided by twice the reload value. When the enable field is zero and the timer-enable control bit is set, the same counter runs as an interval timer. Each timeout sets a sticky interrupt flag.

Software loads the reload value one byte at a time through a small byte-wide register port. The value takes effect at the next reload of the counter. A reload value of zero stands for 65536 counts. This gives the slowest serial rate, a total divide of 131072, and the longest timer interval.

Top module: `sclk_interval_gen`

## Requirements
- R1: The reload value is two byte registers: address 0 holds bits 7:0 and address 1 holds bits 15:8. A write changes only the addressed byte. Both bytes read back on `reg_rdata` at their addresses.
- R2: When `port_en` is not 2'b00, `sclk_stb` pulses once every N system clocks, where N is the effective reload value. The first pulse is seen N+1 clocks after the mode takes effect.
- R3: A reload value of 0x0000 acts as N = 65536.
- R4: When `port_en` is 2'b00 and `tmr_en` is 1, `tmr_irq` is set after each timeout. Timeouts are N clocks apart, and the first comes N+1 clocks after the mode takes effect.
- R5: `tmr_irq` stays set until a write to address 2 has bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set. A timeout on the same edge as a clear wins. Address 2 reads as {7'b0, flag}.
- R6: `tmr_irq` is never set while `tmr_en` is 0, and never set while `port_en` is not 2'b00.
- R7: A write to a reload byte in the middle of a count does not change the count in progress. The new value is used from the next reload.
- R8: A change of operating mode reloads the counter, so the first event after the change comes N+1 clocks later.
- R9: A synchronous reset (`rst` high at a clock edge) clears both reload bytes, the interrupt flag and the strobe.
- R10: `sclk_stb` is never high unless `port_en` was non-zero in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 low byte, 1 high byte, 2 flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| port_en | input | 2 | Serial peripheral enable field; 2'b00 means off |
| tmr_en | input | 1 | Enables timer function and its interrupt |
| sclk_stb | output | 1 | One-cycle serial clock toggle strobe |
| tmr_irq | output | 1 | Sticky timeout interrupt flag |

## Verification
The assertions check four rules on every cycle:
- the interrupt flag never rises outside timer mode;
- the flag only falls under a clear write;
- the strobe only appears in serial mode;
- reset and byte writes act on the reload register as specified.

Some behaviours are about exact intervals, so only the bench scenarios can show them. These are the distance between strobes or timeouts for several reload values, the 65536 count for zero, the reload on a mode change, and the deferral of a mid-count write to the next reload.

// File: rtl/sig_gen_pkg.sv
package sig_gen_pkg;
    localparam int BYTE_W   = 8;
    localparam int RELOAD_W = 16;
    localparam int ADDR_W   = 2;
    localparam int EN_W     = 2;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SERIAL = 2'd1,
        MODE_TIMER  = 2'd2
    } run_mode_e;
endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import sig_gen_pkg::*;
#(
    parameter int RLD_W  = RELOAD_W,
    parameter int AD_W   = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AD_W-1:0]   addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag_set,
    output logic [RLD_W-1:0]  reload,
    output logic              flag,
    output logic [BYTE_W-1:0] rdata
);
    localparam int NBYTES    = RLD_W / BYTE_W;
    localparam int FLAG_ADDR = NBYTES;

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] bytes;
        logic                          flag;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (wr_en && addr == AD_W'(i))
                st_d.bytes[i] = wdata;
        end
        if (wr_en && addr == AD_W'(FLAG_ADDR) && wdata[0])
            st_d.flag = 1'b0;
        if (flag_set)
            st_d.flag = 1'b1;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == AD_W'(i))
                rdata = st_q.bytes[i];
        end
        if (addr == AD_W'(FLAG_ADDR))
            rdata = {{(BYTE_W-1){1'b0}}, st_q.flag};
    end

    assign reload = st_q.bytes;
    assign flag   = st_q.flag;
endmodule

// File: rtl/brg_counter.sv
module brg_counter
    import sig_gen_pkg::*;
#(
    parameter int RLD_W = RELOAD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EN_W-1:0]  port_en,
    input  logic             tmr_en,
    input  logic [RLD_W-1:0] reload,
    output logic             term,
    output run_mode_e        mode
);
    localparam int CNT_W = RLD_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        run_mode_e        mode;
    } cnt_t;

    cnt_t      st_d, st_q;
    run_mode_e want_mode;
    logic [CNT_W-1:0] eff_load;

    always_comb begin
        if (port_en != '0)
            want_mode = MODE_SERIAL;
        else if (tmr_en)
            want_mode = MODE_TIMER;
        else
            want_mode = MODE_IDLE;
    end

    // zero stands for the full 2**RLD_W count
    always_comb begin
        if (reload == '0)
            eff_load = {1'b1, {RLD_W{1'b0}}};
        else
            eff_load = {1'b0, reload};
    end

    always_comb begin
        st_d = st_q;
        term = 1'b0;
        if (rst) begin
            st_d.cnt  = '0;
            st_d.mode = MODE_IDLE;
        end else if (want_mode != st_q.mode) begin
            st_d.cnt  = eff_load;
            st_d.mode = want_mode;
        end else if (st_q.mode == MODE_IDLE) begin
            st_d.cnt = eff_load;
        end else if (st_q.cnt == CNT_W'(1)) begin
            term     = 1'b1;
            st_d.cnt = eff_load;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode = st_q.mode;
endmodule

// File: rtl/sclk_interval_gen.sv
module sclk_interval_gen
    import sig_gen_pkg::*;
#(
    parameter int RLD_W = RELOAD_W,
    parameter int AD_W  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [AD_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [EN_W-1:0]   port_en,
    input  logic              tmr_en,
    output logic              sclk_stb,
    output logic              tmr_irq
);
    typedef struct packed {
        logic stb;
    } out_t;

    logic [RLD_W-1:0] reload_val;
    logic             term;
    logic             flag_set;
    run_mode_e        cur_mode;
    out_t             out_d, out_q;

    brg_regs #(.RLD_W(RLD_W), .AD_W(AD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .flag_set (flag_set),
        .reload   (reload_val),
        .flag     (tmr_irq),
        .rdata    (reg_rdata)
    );

    brg_counter #(.RLD_W(RLD_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .port_en (port_en),
        .tmr_en  (tmr_en),
        .reload  (reload_val),
        .term    (term),
        .mode    (cur_mode)
    );

    assign flag_set = term && (cur_mode == MODE_TIMER);

    always_comb begin
        out_d     = out_q;
        out_d.stb = term && (cur_mode == MODE_SERIAL);
        if (rst)
            out_d = '0;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign sclk_stb = out_q.stb;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
    parameter int RLD_W = 16,
    parameter int AD_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [AD_W-1:0]  reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [1:0]       port_en,
    input logic             tmr_en,
    input logic [RLD_W-1:0] reload,
    input logic             sclk_stb,
    input logic             tmr_irq
);
    localparam int NBYTES = RLD_W / 8;

    // R10: strobe only follows a serial-mode cycle
    assert_stb_serial_R10: assert property (@(posedge clk) disable iff (rst)
        sclk_stb |-> ($past(port_en) != 2'b00));

    // R6: flag rises only from timer mode
    assert_irq_timer_only_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_irq) |-> ($past(port_en) == 2'b00 && $past(tmr_en)));

    // R5: flag falls only under a clear write
    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (tmr_irq && !(reg_wr_en && reg_addr == AD_W'(NBYTES) && reg_wdata[0]))
        |=> tmr_irq);

    // R9: synchronous reset clears state
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!tmr_irq && !sclk_stb && reload == '0));

    // R1: byte write lands in its own lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assert_byte_load_R1: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_en && reg_addr == AD_W'(b)) |=> (reload[b*8 +: 8] == $past(reg_wdata)));
    end
endmodule

bind sclk_interval_gen brg_checker #(.RLD_W(RLD_W), .AD_W(AD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .port_en   (port_en),
    .tmr_en    (tmr_en),
    .reload    (reload_val),
    .sclk_stb  (sclk_stb),
    .tmr_irq   (tmr_irq)
);

// File: tb/tb_sclk_interval_gen.sv
`timescale 1ns/1ps
module tb_sclk_interval_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] port_en = 2'b00;
    logic       tmr_en = 1'b0;
    logic       sclk_stb;
    logic       tmr_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sclk_interval_gen dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_en(port_en),
        .tmr_en(tmr_en), .sclk_stb(sclk_stb), .tmr_irq(tmr_irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [15:0] rl;
        logic [1:0]  pe;
        logic        tm;
        logic [17:0] exp_first;
        logic [17:0] exp_next;
    } vec_t;

    // serial: first = N+1, next = N; timer: first = N+1, next after clear = N-1
    localparam vec_t VECS [6] = '{
        '{rl:16'h0003, pe:2'b01, tm:1'b0, exp_first:18'd4,   exp_next:18'd3},
        '{rl:16'h0001, pe:2'b11, tm:1'b0, exp_first:18'd2,   exp_next:18'd1},
        '{rl:16'h0105, pe:2'b10, tm:1'b0, exp_first:18'd262, exp_next:18'd261},
        '{rl:16'h0002, pe:2'b00, tm:1'b1, exp_first:18'd3,   exp_next:18'd1},
        '{rl:16'h00FF, pe:2'b00, tm:1'b1, exp_first:18'd256, exp_next:18'd254},
        '{rl:16'h0100, pe:2'b00, tm:1'b1, exp_first:18'd257, exp_next:18'd255}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic wait_evt(input bit use_irq, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_irq ? tmr_irq : sclk_stb) && n < 70000);
    endtask

    task automatic go_idle();
        port_en = 2'b00;
        tmr_en  = 1'b0;
        @(negedge clk);
        wr(2'd2, 8'h01);
    endtask

    initial begin
        int v;
        int n;
        int cnt_a;
        int cnt_b;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        rd(2'd0, v); chk("R9 low byte after reset", v, 0);
        rd(2'd1, v); chk("R9 high byte after reset", v, 0);
        rd(2'd2, v); chk("R9 flag after reset", v, 0);
        chk("R9 strobe after reset", int'(sclk_stb), 0);

        // R1: byte independence
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h3C);
        wr(2'd1, 8'h7E);
        rd(2'd0, v); chk("R1 low byte kept", v, 'hA5);
        rd(2'd1, v); chk("R1 high byte written", v, 'h7E);

        // vector table: R2 serial intervals, R4 timer intervals
        foreach (VECS[i]) begin
            go_idle();
            wr(2'd0, VECS[i].rl[7:0]);
            wr(2'd1, VECS[i].rl[15:8]);
            rd(2'd0, v); chk("R1 table low byte", v, int'(VECS[i].rl[7:0]));
            rd(2'd1, v); chk("R1 table high byte", v, int'(VECS[i].rl[15:8]));
            port_en = VECS[i].pe;
            tmr_en  = VECS[i].tm;
            wait_evt(VECS[i].tm, n);
            chk(VECS[i].tm ? "R4 first timeout" : "R2 first strobe", n, int'(VECS[i].exp_first));
            if (VECS[i].tm) begin
                wr(2'd2, 8'h01);
                wait_evt(1'b1, n);
                chk("R4 next timeout", n, int'(VECS[i].exp_next));
            end else begin
                wait_evt(1'b0, n);
                chk("R2 next strobe", n, int'(VECS[i].exp_next));
            end
        end

        // R5: sticky flag and clear rules
        go_idle();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h00);
        tmr_en = 1'b1;
        wait_evt(1'b1, n);
        tmr_en = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 flag held with timer off", int'(tmr_irq), 1);
        wr(2'd2, 8'h00);
        chk("R5 zero write keeps flag", int'(tmr_irq), 1);
        wr(2'd2, 8'hFE);
        rd(2'd2, v); chk("R5 bit0 clear write keeps flag", v, 1);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R5 flag cleared", v, 0);

        // R6/R10: idle mode raises nothing
        cnt_a = 0; cnt_b = 0;
        repeat (30) begin
            @(negedge clk);
            if (tmr_irq) cnt_a++;
            if (sclk_stb) cnt_b++;
        end
        chk("R6 no flag with timer off", cnt_a, 0);
        chk("R10 no strobe when idle", cnt_b, 0);

        // R6/R2: serial mode with timer bit set
        tmr_en = 1'b1;
        port_en = 2'b01;
        cnt_a = 0; cnt_b = 0;
        repeat (30) begin
            @(negedge clk);
            if (tmr_irq) cnt_a++;
            if (sclk_stb) cnt_b++;
        end
        chk("R6 no flag in serial mode", cnt_a, 0);
        chk("R2 strobe count N=2 over 30", cnt_b, 14);

        // R3: zero reload counts 65536
        go_idle();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        tmr_en = 1'b1;
        wait_evt(1'b1, n);
        chk("R3 zero reload interval", n, 65537);

        // R7: mid-count write deferred
        go_idle();
        wr(2'd0, 8'd10);
        tmr_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) begin
                reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd4;
            end else begin
                reg_wr_en = 1'b0;
            end
        end while (!tmr_irq && n < 1000);
        chk("R7 count in progress unchanged", n, 11);
        wr(2'd2, 8'h01);
        wait_evt(1'b1, n);
        chk("R7 new value after reload", n, 3);

        // R9: reset mid run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        tmr_en = 1'b0;
        chk("R9 flag cleared by reset", int'(tmr_irq), 0);
        rd(2'd0, v); chk("R9 low byte cleared by reset", v, 0);

        // R8: mode change reloads
        go_idle();
        wr(2'd0, 8'd6);
        port_en = 2'b01;
        repeat (4) @(negedge clk);
        port_en = 2'b00;
        tmr_en  = 1'b1;
        wait_evt(1'b1, n);
        chk("R8 reload on mode change", n, 7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule